// File: doc/BRIEF.md
# Indexed Display Register Interface

This block is the register front end of a simple display adapter. A host reaches every register through two ports. It writes a register number to the index port. It then reads or writes the selected register through the value port. The file holds a version handshake word, the enable and pending mode registers, cursor control, a guest identity word and a sync flag. It also holds a small scratch window. Several registers are not stored at all: bits per pixel, bytes per line, the maximum mode size and the ring size are computed from parameters and from the pending width.

Before it accepts a command ring, the block checks the ring descriptor. The descriptor has four byte offsets (lower bound, upper bound, next and stop), which the adapter presents as inputs. When the host writes a nonzero value to the configuration register, the block checks those offsets. Only a descriptor that passes sets the configured state and latches the bounds for the ring reader. Pending width and height reach the active mode outputs only on a separate mode update strobe. Enable, configured state, active size, cursor state and a set of one-cycle error pulses go to the neighbouring blocks.

Top module: `disp_index_regs`

## Requirements
- R1: A write to the index port stores the full 32-bit value, and that value appears on the index read port from the next cycle.
- R2: Register 0 resets to 0x90000002. A value-port write to it is stored only if it equals 0x90000000, 0x90000001 or 0x90000002. Any other written value leaves the register unchanged and raises no error.
- R3: A write to register 1 sets the enable output to 1 when the written value is nonzero and to 0 when it is zero. A zero write also clears the configured output. Register 1 reads back the enable bit.
- R4: The following registers read back constants: register 4 reads 2360, register 5 reads 1770, register 17 reads the capability word (0 by default), register 19 reads 0x10000 and register 29 reads the scratch word count (16 by default).
- R5: Register 7 reads (depth+7) with its low three bits cleared, which is 24 at the default depth of 24. A write equal to that depth is accepted with no effect. Any other value pulses the depth error output for one cycle, and the register still reads the same.
- R6: Registers 2 and 3 read back the pending width and height. Register 12 reads ((depth+7)>>3) times the pending width.
- R7: The width and height outputs change only on a mode update strobe. On that strobe, the pending values are copied to the outputs when they differ from them, and the size-changed output is high for the one following cycle. A strobe that finds no difference produces no pulse.
- R8: A nonzero write to register 20 whose ring descriptor passes all checks sets the configured output and latches the lower and upper bounds onto the ring outputs. A zero write clears the configured output. Register 20 reads back the configured bit.
- R9: The descriptor check rejects the offsets when any of them is not a multiple of 4, or when the upper bound exceeds 0x10000, or when the upper bound is less than the lower bound plus 10240. A rejected nonzero write to register 20 leaves the configured output and the ring outputs unchanged and pulses the ring error output for one cycle.
- R10: Registers 24, 25 and 26 store and return the cursor id, X and Y, which drive the cursor outputs. A write of 1 to register 27 makes the cursor visible and a write of 0 hides it. Writes of 2 or 3 leave visibility unchanged. Register 27 reads the visibility bit.
- R11: Indices 1792 up to 1792 plus the scratch word count minus one read and write scratch words. The scratch words reset to 0.
- R12: A value-port read of an index with no register, a read or write just above the scratch window, or a write to a read-only register pulses the bad register output on the following cycle and changes no state. Such a read returns 0.
- R13: A write to register 21 sets the busy flag to whether the value is nonzero. Registers 21 and 22 read that flag. Register 23 stores and returns the guest identity word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWr | input | 1 | Index port write strobe |
| idxWdata | input | 32 | Index value to store |
| idxRdata | output | 32 | Currently selected index |
| valWr | input | 1 | Value port write strobe |
| valRd | input | 1 | Value port read strobe (used for bad-index flagging) |
| valWdata | input | 32 | Value port write data |
| valRdata | output | 32 | Selected register contents, combinational |
| modeUpdate | input | 1 | Copy pending size to active size |
| ringMinIn | input | 32 | Ring lower bound offset in bytes |
| ringMaxIn | input | 32 | Ring upper bound offset in bytes |
| ringNextIn | input | 32 | Ring next offset in bytes |
| ringStopIn | input | 32 | Ring stop offset in bytes |
| enableOut | output | 1 | Adapter enabled |
| configOut | output | 1 | Command ring accepted |
| widthOut | output | 32 | Active width |
| heightOut | output | 32 | Active height |
| cursorIdOut | output | 32 | Cursor id |
| cursorXOut | output | 32 | Cursor X |
| cursorYOut | output | 32 | Cursor Y |
| cursorVisible | output | 1 | Cursor shown |
| ringBase | output | 32 | Latched ring lower bound |
| ringLimit | output | 32 | Latched ring upper bound |
| sizeChanged | output | 1 | One-cycle pulse after an active size change |
| badReg | output | 1 | One-cycle pulse after an access to a bad index |
| depthErr | output | 1 | One-cycle pulse after a mismatched depth write |
| ringErr | output | 1 | One-cycle pulse after a rejected ring descriptor |

## Verification
Most of the state can be read back through the value port, so a corrupted register shows up on valRdata at the next read of that index. That read can come on the cycle right after the index write. The derived reads of bits per pixel and bytes per line expose a wrong depth constant or a stale pending width at once. A descriptor check that is wrong in either direction shows up one cycle after the configuration write, on configOut or on the ring error pulse. A decode mistake shows up one cycle after the access, on the bad register pulse, and the read that follows shows whether a neighbouring register was disturbed.

// File: rtl/disp_regs_pkg.sv
package disp_regs_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [31:0] IX_ID        = 32'd0;
  localparam logic [31:0] IX_ENABLE    = 32'd1;
  localparam logic [31:0] IX_WIDTH     = 32'd2;
  localparam logic [31:0] IX_HEIGHT    = 32'd3;
  localparam logic [31:0] IX_MAXW      = 32'd4;
  localparam logic [31:0] IX_MAXH      = 32'd5;
  localparam logic [31:0] IX_BPP       = 32'd7;
  localparam logic [31:0] IX_BPL       = 32'd12;
  localparam logic [31:0] IX_CAPS      = 32'd17;
  localparam logic [31:0] IX_MEMSTART  = 32'd18;
  localparam logic [31:0] IX_MEMSIZE   = 32'd19;
  localparam logic [31:0] IX_CONFIG    = 32'd20;
  localparam logic [31:0] IX_SYNC      = 32'd21;
  localparam logic [31:0] IX_BUSY      = 32'd22;
  localparam logic [31:0] IX_GUEST     = 32'd23;
  localparam logic [31:0] IX_CURID     = 32'd24;
  localparam logic [31:0] IX_CURX      = 32'd25;
  localparam logic [31:0] IX_CURY      = 32'd26;
  localparam logic [31:0] IX_CURON     = 32'd27;
  localparam logic [31:0] IX_SCRSIZE   = 32'd29;
  localparam logic [31:0] SCRATCH_BASE = 32'd1792;

  localparam logic [23:0] ID_PREFIX = 24'h900000;
  localparam logic [31:0] ID_V0 = {ID_PREFIX, 8'd0};
  localparam logic [31:0] ID_V1 = {ID_PREFIX, 8'd1};
  localparam logic [31:0] ID_V2 = {ID_PREFIX, 8'd2};

  localparam logic [32:0] RING_MIN_SPAN = 33'd10240;

  typedef enum logic [4:0] {
    RS_ZERO, RS_ID, RS_ENABLE, RS_WIDTH, RS_HEIGHT, RS_MAXW, RS_MAXH,
    RS_BPP, RS_BPL, RS_CAPS, RS_MEMSTART, RS_MEMSIZE, RS_CONFIG,
    RS_BUSY, RS_GUEST, RS_CURID, RS_CURX, RS_CURY, RS_CURON,
    RS_SCRSIZE, RS_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic   wrId;
    logic   wrEnable;
    logic   wrWidth;
    logic   wrHeight;
    logic   wrDepth;
    logic   wrConfig;
    logic   wrSync;
    logic   wrGuest;
    logic   wrCurId;
    logic   wrCurX;
    logic   wrCurY;
    logic   wrCurOn;
    logic   wrScratch;
    rdSel_e rdSel;
  } regCmd_t;

endpackage

// File: rtl/disp_regs_ctrl.sv
module disp_regs_ctrl
  import disp_regs_pkg::*;
#(
  parameter int unsigned SCRATCH_WORDS = 16,
  localparam int unsigned SCR_IDX_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 valWr,
  input  logic                 valRd,
  input  logic [31:0]          curIndex,
  output regCmd_t              cmd,
  output logic [SCR_IDX_W-1:0] scratchIdx,
  output logic                 badReg
);

  localparam logic [31:0] SCRATCH_END = SCRATCH_BASE + 32'(SCRATCH_WORDS);

  logic   inWindow;
  logic   rdKnown;
  logic   wrKnown;
  rdSel_e sel;
  logic [31:0] offset;

  assign offset     = curIndex - SCRATCH_BASE;
  assign inWindow   = (curIndex >= SCRATCH_BASE) && (curIndex < SCRATCH_END);
  assign scratchIdx = offset[SCR_IDX_W-1:0];

  // Read decode: which source feeds the value port
  always_comb begin
    sel     = RS_ZERO;
    rdKnown = 1'b1;
    unique case (curIndex)
      IX_ID:       sel = RS_ID;
      IX_ENABLE:   sel = RS_ENABLE;
      IX_WIDTH:    sel = RS_WIDTH;
      IX_HEIGHT:   sel = RS_HEIGHT;
      IX_MAXW:     sel = RS_MAXW;
      IX_MAXH:     sel = RS_MAXH;
      IX_BPP:      sel = RS_BPP;
      IX_BPL:      sel = RS_BPL;
      IX_CAPS:     sel = RS_CAPS;
      IX_MEMSTART: sel = RS_MEMSTART;
      IX_MEMSIZE:  sel = RS_MEMSIZE;
      IX_CONFIG:   sel = RS_CONFIG;
      IX_SYNC:     sel = RS_BUSY;
      IX_BUSY:     sel = RS_BUSY;
      IX_GUEST:    sel = RS_GUEST;
      IX_CURID:    sel = RS_CURID;
      IX_CURX:     sel = RS_CURX;
      IX_CURY:     sel = RS_CURY;
      IX_CURON:    sel = RS_CURON;
      IX_SCRSIZE:  sel = RS_SCRSIZE;
      default: begin
        if (inWindow) sel = RS_SCRATCH;
        else          rdKnown = 1'b0;
      end
    endcase
  end

  // Write decode: one strobe per writable register
  always_comb begin
    cmd       = '0;
    cmd.rdSel = sel;
    wrKnown   = 1'b1;
    unique case (curIndex)
      IX_ID:     cmd.wrId     = valWr;
      IX_ENABLE: cmd.wrEnable = valWr;
      IX_WIDTH:  cmd.wrWidth  = valWr;
      IX_HEIGHT: cmd.wrHeight = valWr;
      IX_BPP:    cmd.wrDepth  = valWr;
      IX_CONFIG: cmd.wrConfig = valWr;
      IX_SYNC:   cmd.wrSync   = valWr;
      IX_GUEST:  cmd.wrGuest  = valWr;
      IX_CURID:  cmd.wrCurId  = valWr;
      IX_CURX:   cmd.wrCurX   = valWr;
      IX_CURY:   cmd.wrCurY   = valWr;
      IX_CURON:  cmd.wrCurOn  = valWr;
      default: begin
        if (inWindow) cmd.wrScratch = valWr;
        else          wrKnown = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) badReg <= 1'b0;
    else       badReg <= (valWr && !wrKnown) || (valRd && !rdKnown);
  end

endmodule

// File: rtl/disp_regs_dp.sv
module disp_regs_dp
  import disp_regs_pkg::*;
#(
  parameter int unsigned COLOR_DEPTH    = 24,
  parameter int unsigned MAX_W          = 2360,
  parameter int unsigned MAX_H          = 1770,
  parameter int unsigned SCRATCH_WORDS  = 16,
  parameter int unsigned RESET_W        = 640,
  parameter int unsigned RESET_H        = 480,
  parameter logic [31:0] CAPS_WORD      = 32'h0,
  parameter logic [31:0] MEM_START_ADDR = 32'hE0FF_0000,
  parameter logic [31:0] RING_BYTES     = 32'h0001_0000,
  localparam int unsigned SCR_IDX_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idxWr,
  input  logic [31:0]          idxWdata,
  input  logic [31:0]          valWdata,
  input  regCmd_t              cmd,
  input  logic [SCR_IDX_W-1:0] scratchIdx,
  input  logic                 modeUpdate,
  input  logic [31:0]          ringMinIn,
  input  logic [31:0]          ringMaxIn,
  input  logic [31:0]          ringNextIn,
  input  logic [31:0]          ringStopIn,
  output logic [31:0]          curIndex,
  output logic [31:0]          valRdata,
  output logic                 enableOut,
  output logic                 configOut,
  output logic [31:0]          widthOut,
  output logic [31:0]          heightOut,
  output logic [31:0]          cursorIdOut,
  output logic [31:0]          cursorXOut,
  output logic [31:0]          cursorYOut,
  output logic                 cursorVisible,
  output logic [31:0]          ringBase,
  output logic [31:0]          ringLimit,
  output logic                 sizeChanged,
  output logic                 depthErr,
  output logic                 ringErr
);

  localparam logic [31:0] BPP_VAL   = 32'((COLOR_DEPTH + 7) & ~7);
  localparam logic [31:0] BYTES_PP  = 32'((COLOR_DEPTH + 7) >> 3);
  localparam logic [31:0] MAXW_VAL  = 32'(MAX_W);
  localparam logic [31:0] MAXH_VAL  = 32'(MAX_H);
  localparam logic [31:0] SCR_COUNT = 32'(SCRATCH_WORDS);

  logic [31:0] idReg;
  logic [31:0] widthPend;
  logic [31:0] heightPend;
  logic [31:0] guestReg;
  logic        busyFlag;
  logic [31:0] scratchMem [SCRATCH_WORDS];

  logic        wrNonZero;
  logic        alignOk;
  logic        maxOk;
  logic        spanOk;
  logic        ringOk;
  logic        idOk;
  logic [31:0] bplVal;

  assign wrNonZero = |valWdata;
  assign alignOk   = ((ringMinIn | ringMaxIn | ringNextIn | ringStopIn) & 32'd3) == 32'd0;
  assign maxOk     = ringMaxIn <= RING_BYTES;
  assign spanOk    = {1'b0, ringMaxIn} >= ({1'b0, ringMinIn} + RING_MIN_SPAN);
  assign ringOk    = alignOk && maxOk && spanOk;
  assign idOk      = (valWdata == ID_V0) || (valWdata == ID_V1) || (valWdata == ID_V2);
  assign bplVal    = BYTES_PP * widthPend;

  // Index register
  always_ff @(posedge clk) begin
    if (!rstN)      curIndex <= '0;
    else if (idxWr) curIndex <= idxWdata;
  end

  // Identity, enable and configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg     <= ID_V2;
      enableOut <= 1'b0;
      configOut <= 1'b0;
      ringBase  <= '0;
      ringLimit <= '0;
      ringErr   <= 1'b0;
    end else begin
      ringErr <= 1'b0;
      if (cmd.wrId && idOk) idReg <= valWdata;
      if (cmd.wrEnable) begin
        enableOut <= wrNonZero;
        if (!wrNonZero) configOut <= 1'b0;
      end
      if (cmd.wrConfig) begin
        if (!wrNonZero) begin
          configOut <= 1'b0;
        end else if (ringOk) begin
          configOut <= 1'b1;
          ringBase  <= ringMinIn;
          ringLimit <= ringMaxIn;
        end else begin
          ringErr <= 1'b1;
        end
      end
    end
  end

  // Mode registers: pending values, active copy on the update strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthPend   <= 32'(RESET_W);
      heightPend  <= 32'(RESET_H);
      widthOut    <= 32'(RESET_W);
      heightOut   <= 32'(RESET_H);
      sizeChanged <= 1'b0;
      depthErr    <= 1'b0;
    end else begin
      sizeChanged <= 1'b0;
      depthErr    <= cmd.wrDepth && (valWdata != 32'(COLOR_DEPTH));
      if (cmd.wrWidth)  widthPend  <= valWdata;
      if (cmd.wrHeight) heightPend <= valWdata;
      if (modeUpdate && ((widthPend != widthOut) || (heightPend != heightOut))) begin
        widthOut    <= widthPend;
        heightOut   <= heightPend;
        sizeChanged <= 1'b1;
      end
    end
  end

  // Cursor, guest and sync
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cursorIdOut   <= '0;
      cursorXOut    <= '0;
      cursorYOut    <= '0;
      cursorVisible <= 1'b0;
      guestReg      <= '0;
      busyFlag      <= 1'b0;
    end else begin
      if (cmd.wrCurId) cursorIdOut <= valWdata;
      if (cmd.wrCurX)  cursorXOut  <= valWdata;
      if (cmd.wrCurY)  cursorYOut  <= valWdata;
      if (cmd.wrCurOn) begin
        if (valWdata == 32'd1)      cursorVisible <= 1'b1;
        else if (valWdata == 32'd0) cursorVisible <= 1'b0;
      end
      if (cmd.wrGuest) guestReg <= valWdata;
      if (cmd.wrSync)  busyFlag <= wrNonZero;
    end
  end

  // Scratch window, one register per word
  for (genvar g = 0; g < SCRATCH_WORDS; g++) begin : gScratch
    always_ff @(posedge clk) begin
      if (!rstN)
        scratchMem[g] <= '0;
      else if (cmd.wrScratch && (32'(scratchIdx) == 32'(g)))
        scratchMem[g] <= valWdata;
    end
  end

  // Read mux
  always_comb begin
    unique case (cmd.rdSel)
      RS_ID:       valRdata = idReg;
      RS_ENABLE:   valRdata = {31'd0, enableOut};
      RS_WIDTH:    valRdata = widthPend;
      RS_HEIGHT:   valRdata = heightPend;
      RS_MAXW:     valRdata = MAXW_VAL;
      RS_MAXH:     valRdata = MAXH_VAL;
      RS_BPP:      valRdata = BPP_VAL;
      RS_BPL:      valRdata = bplVal;
      RS_CAPS:     valRdata = CAPS_WORD;
      RS_MEMSTART: valRdata = MEM_START_ADDR;
      RS_MEMSIZE:  valRdata = RING_BYTES;
      RS_CONFIG:   valRdata = {31'd0, configOut};
      RS_BUSY:     valRdata = {31'd0, busyFlag};
      RS_GUEST:    valRdata = guestReg;
      RS_CURID:    valRdata = cursorIdOut;
      RS_CURX:     valRdata = cursorXOut;
      RS_CURY:     valRdata = cursorYOut;
      RS_CURON:    valRdata = {31'd0, cursorVisible};
      RS_SCRSIZE:  valRdata = SCR_COUNT;
      RS_SCRATCH:  valRdata = scratchMem[scratchIdx];
      default:     valRdata = '0;
    endcase
  end

endmodule

// File: rtl/disp_index_regs.sv
module disp_index_regs
  import disp_regs_pkg::*;
#(
  parameter int unsigned COLOR_DEPTH    = 24,
  parameter int unsigned MAX_W          = 2360,
  parameter int unsigned MAX_H          = 1770,
  parameter int unsigned SCRATCH_WORDS  = 16,
  parameter int unsigned RESET_W        = 640,
  parameter int unsigned RESET_H        = 480,
  parameter logic [31:0] CAPS_WORD      = 32'h0,
  parameter logic [31:0] MEM_START_ADDR = 32'hE0FF_0000,
  parameter logic [31:0] RING_BYTES     = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idxWr,
  input  logic [31:0] idxWdata,
  output logic [31:0] idxRdata,
  input  logic        valWr,
  input  logic        valRd,
  input  logic [31:0] valWdata,
  output logic [31:0] valRdata,
  input  logic        modeUpdate,
  input  logic [31:0] ringMinIn,
  input  logic [31:0] ringMaxIn,
  input  logic [31:0] ringNextIn,
  input  logic [31:0] ringStopIn,
  output logic        enableOut,
  output logic        configOut,
  output logic [31:0] widthOut,
  output logic [31:0] heightOut,
  output logic [31:0] cursorIdOut,
  output logic [31:0] cursorXOut,
  output logic [31:0] cursorYOut,
  output logic        cursorVisible,
  output logic [31:0] ringBase,
  output logic [31:0] ringLimit,
  output logic        sizeChanged,
  output logic        badReg,
  output logic        depthErr,
  output logic        ringErr
);

  localparam int unsigned SCR_IDX_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;

  regCmd_t              cmd;
  logic [SCR_IDX_W-1:0] scratchIdx;
  logic [31:0]          curIndex;

  assign idxRdata = curIndex;

  disp_regs_ctrl #(
    .SCRATCH_WORDS(SCRATCH_WORDS)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .valWr     (valWr),
    .valRd     (valRd),
    .curIndex  (curIndex),
    .cmd       (cmd),
    .scratchIdx(scratchIdx),
    .badReg    (badReg)
  );

  disp_regs_dp #(
    .COLOR_DEPTH   (COLOR_DEPTH),
    .MAX_W         (MAX_W),
    .MAX_H         (MAX_H),
    .SCRATCH_WORDS (SCRATCH_WORDS),
    .RESET_W       (RESET_W),
    .RESET_H       (RESET_H),
    .CAPS_WORD     (CAPS_WORD),
    .MEM_START_ADDR(MEM_START_ADDR),
    .RING_BYTES    (RING_BYTES)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .idxWr        (idxWr),
    .idxWdata     (idxWdata),
    .valWdata     (valWdata),
    .cmd          (cmd),
    .scratchIdx   (scratchIdx),
    .modeUpdate   (modeUpdate),
    .ringMinIn    (ringMinIn),
    .ringMaxIn    (ringMaxIn),
    .ringNextIn   (ringNextIn),
    .ringStopIn   (ringStopIn),
    .curIndex     (curIndex),
    .valRdata     (valRdata),
    .enableOut    (enableOut),
    .configOut    (configOut),
    .widthOut     (widthOut),
    .heightOut    (heightOut),
    .cursorIdOut  (cursorIdOut),
    .cursorXOut   (cursorXOut),
    .cursorYOut   (cursorYOut),
    .cursorVisible(cursorVisible),
    .ringBase     (ringBase),
    .ringLimit    (ringLimit),
    .sizeChanged  (sizeChanged),
    .depthErr     (depthErr),
    .ringErr      (ringErr)
  );

endmodule

// File: rtl/disp_regs_checker.sv
module disp_regs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        idxWr,
  input logic [31:0] idxWdata,
  input logic [31:0] idxRdata,
  input logic        valWr,
  input logic [31:0] valWdata,
  input logic        modeUpdate,
  input logic        enableOut,
  input logic        configOut,
  input logic [31:0] widthOut,
  input logic [31:0] heightOut,
  input logic        cursorVisible,
  input logic [31:0] ringBase,
  input logic        sizeChanged,
  input logic        badReg,
  input logic        ringErr
);

  assert_index_echo_R1: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (idxRdata == $past(idxWdata)));

  assert_enable_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (valWr && idxRdata == 32'd1 && valWdata == 32'd0) |=> (!enableOut && !configOut));

  assert_size_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(widthOut) || !$stable(heightOut)) |-> $past(modeUpdate));

  assert_size_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sizeChanged |-> $past(modeUpdate));

  assert_config_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(configOut) |-> $past(valWr && idxRdata == 32'd20 && valWdata != 32'd0));

  assert_ring_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    ringErr |-> ($stable(configOut) && $stable(ringBase)));

  assert_cursor_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (valWr && idxRdata == 32'd27 && valWdata > 32'd1) |=> $stable(cursorVisible));

  assert_bad_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    badReg |-> ($stable(enableOut) && $stable(configOut) && $stable(cursorVisible)));

endmodule

bind disp_index_regs disp_regs_checker uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .idxWr        (idxWr),
  .idxWdata     (idxWdata),
  .idxRdata     (idxRdata),
  .valWr        (valWr),
  .valWdata     (valWdata),
  .modeUpdate   (modeUpdate),
  .enableOut    (enableOut),
  .configOut    (configOut),
  .widthOut     (widthOut),
  .heightOut    (heightOut),
  .cursorVisible(cursorVisible),
  .ringBase     (ringBase),
  .sizeChanged  (sizeChanged),
  .badReg       (badReg),
  .ringErr      (ringErr)
);

// File: tb/disp_index_regs_test.sv
module disp_index_regs_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        isRd;
    logic [15:0] idx;
    logic [31:0] data;
    logic        expBad;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 57;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'd0,    32'h90000002, 1'b0, 8'd2},  // R2 reset id
    '{1'b0, 16'd0,    32'h90000000, 1'b0, 8'd2},
    '{1'b1, 16'd0,    32'h90000000, 1'b0, 8'd2},
    '{1'b0, 16'd0,    32'h12345678, 1'b0, 8'd2},  // R2 invalid id ignored
    '{1'b1, 16'd0,    32'h90000000, 1'b0, 8'd2},
    '{1'b0, 16'd0,    32'h90000001, 1'b0, 8'd2},
    '{1'b1, 16'd0,    32'h90000001, 1'b0, 8'd2},
    '{1'b1, 16'd4,    32'd2360,     1'b0, 8'd4},  // R4 constants
    '{1'b1, 16'd5,    32'd1770,     1'b0, 8'd4},
    '{1'b1, 16'd19,   32'h00010000, 1'b0, 8'd4},
    '{1'b1, 16'd29,   32'd16,       1'b0, 8'd4},
    '{1'b1, 16'd7,    32'd24,       1'b0, 8'd5},  // R5 bits per pixel
    '{1'b1, 16'd2,    32'd640,      1'b0, 8'd6},  // R6 pending size
    '{1'b1, 16'd3,    32'd480,      1'b0, 8'd6},
    '{1'b1, 16'd12,   32'd1920,     1'b0, 8'd6},
    '{1'b0, 16'd2,    32'd800,      1'b0, 8'd6},
    '{1'b1, 16'd12,   32'd2400,     1'b0, 8'd6},
    '{1'b1, 16'd2,    32'd800,      1'b0, 8'd6},
    '{1'b0, 16'd3,    32'd600,      1'b0, 8'd6},
    '{1'b1, 16'd3,    32'd600,      1'b0, 8'd6},
    '{1'b0, 16'd1,    32'd1,        1'b0, 8'd3},  // R3 enable
    '{1'b1, 16'd1,    32'd1,        1'b0, 8'd3},
    '{1'b0, 16'd24,   32'd5,        1'b0, 8'd10}, // R10 cursor
    '{1'b1, 16'd24,   32'd5,        1'b0, 8'd10},
    '{1'b0, 16'd25,   32'd100,      1'b0, 8'd10},
    '{1'b1, 16'd25,   32'd100,      1'b0, 8'd10},
    '{1'b0, 16'd26,   32'd200,      1'b0, 8'd10},
    '{1'b1, 16'd26,   32'd200,      1'b0, 8'd10},
    '{1'b0, 16'd27,   32'd1,        1'b0, 8'd10},
    '{1'b1, 16'd27,   32'd1,        1'b0, 8'd10},
    '{1'b0, 16'd27,   32'd2,        1'b0, 8'd10},
    '{1'b1, 16'd27,   32'd1,        1'b0, 8'd10},
    '{1'b0, 16'd27,   32'd0,        1'b0, 8'd10},
    '{1'b1, 16'd27,   32'd0,        1'b0, 8'd10},
    '{1'b0, 16'd27,   32'd3,        1'b0, 8'd10},
    '{1'b1, 16'd27,   32'd0,        1'b0, 8'd10},
    '{1'b0, 16'd1792, 32'hDEAD0001, 1'b0, 8'd11}, // R11 scratch
    '{1'b1, 16'd1792, 32'hDEAD0001, 1'b0, 8'd11},
    '{1'b0, 16'd1807, 32'h0000BEEF, 1'b0, 8'd11},
    '{1'b1, 16'd1807, 32'h0000BEEF, 1'b0, 8'd11},
    '{1'b1, 16'd1793, 32'd0,        1'b0, 8'd11},
    '{1'b1, 16'd1808, 32'd0,        1'b1, 8'd12}, // R12 bad accesses
    '{1'b0, 16'd1808, 32'd1,        1'b1, 8'd12},
    '{1'b1, 16'd6,    32'd0,        1'b1, 8'd12},
    '{1'b0, 16'd4,    32'd7,        1'b1, 8'd12},
    '{1'b1, 16'd4,    32'd2360,     1'b0, 8'd12},
    '{1'b0, 16'd12,   32'd5,        1'b1, 8'd12},
    '{1'b1, 16'd12,   32'd2400,     1'b0, 8'd12},
    '{1'b0, 16'd21,   32'd1,        1'b0, 8'd13}, // R13 sync/busy/guest
    '{1'b1, 16'd22,   32'd1,        1'b0, 8'd13},
    '{1'b1, 16'd21,   32'd1,        1'b0, 8'd13},
    '{1'b0, 16'd21,   32'd0,        1'b0, 8'd13},
    '{1'b1, 16'd22,   32'd0,        1'b0, 8'd13},
    '{1'b0, 16'd23,   32'h00005001, 1'b0, 8'd13},
    '{1'b1, 16'd23,   32'h00005001, 1'b0, 8'd13},
    '{1'b1, 16'd17,   32'd0,        1'b0, 8'd4},
    '{1'b1, 16'd20,   32'd0,        1'b0, 8'd8}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idxWr = 1'b0;
  logic [31:0] idxWdata = '0;
  logic [31:0] idxRdata;
  logic        valWr = 1'b0;
  logic        valRd = 1'b0;
  logic [31:0] valWdata = '0;
  logic [31:0] valRdata;
  logic        modeUpdate = 1'b0;
  logic [31:0] ringMinIn = '0;
  logic [31:0] ringMaxIn = '0;
  logic [31:0] ringNextIn = '0;
  logic [31:0] ringStopIn = '0;
  logic        enableOut, configOut, cursorVisible;
  logic [31:0] widthOut, heightOut, cursorIdOut, cursorXOut, cursorYOut;
  logic [31:0] ringBase, ringLimit;
  logic        sizeChanged, badReg, depthErr, ringErr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rdVal;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disp_index_regs uut (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .idxWdata(idxWdata), .idxRdata(idxRdata),
    .valWr(valWr), .valRd(valRd), .valWdata(valWdata), .valRdata(valRdata),
    .modeUpdate(modeUpdate), .ringMinIn(ringMinIn), .ringMaxIn(ringMaxIn),
    .ringNextIn(ringNextIn), .ringStopIn(ringStopIn), .enableOut(enableOut),
    .configOut(configOut), .widthOut(widthOut), .heightOut(heightOut),
    .cursorIdOut(cursorIdOut), .cursorXOut(cursorXOut), .cursorYOut(cursorYOut),
    .cursorVisible(cursorVisible), .ringBase(ringBase), .ringLimit(ringLimit),
    .sizeChanged(sizeChanged), .badReg(badReg), .depthErr(depthErr), .ringErr(ringErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Index then value write; returns at the negedge after the write edge
  task automatic regWrite(input logic [31:0] idx, input logic [31:0] data);
    @(negedge clk); idxWr = 1'b1; idxWdata = idx;
    @(negedge clk); idxWr = 1'b0; valWr = 1'b1; valWdata = data;
    @(negedge clk); valWr = 1'b0;
  endtask

  task automatic regRead(input logic [31:0] idx, output logic [31:0] data);
    @(negedge clk); idxWr = 1'b1; idxWdata = idx;
    @(negedge clk); idxWr = 1'b0; valRd = 1'b1;
    #1 data = valRdata;
    @(negedge clk); valRd = 1'b0;
  endtask

  task automatic setRing(input logic [31:0] mn, input logic [31:0] mx,
                         input logic [31:0] nx, input logic [31:0] st);
    ringMinIn = mn; ringMaxIn = mx; ringNextIn = nx; ringStopIn = st;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset enable", {31'd0, enableOut}, 32'd0);
    chk("R8 reset config", {31'd0, configOut}, 32'd0);
    chk("R7 reset width", widthOut, 32'd640);
    chk("R7 reset height", heightOut, 32'd480);
    chk("R1 reset index", idxRdata, 32'd0);
    chk("R12 reset badReg", {31'd0, badReg}, 32'd0);

    // R1 index echo
    @(negedge clk); idxWr = 1'b1; idxWdata = 32'hA5A5_1234;
    @(negedge clk); idxWr = 1'b0;
    chk("R1 index echo", idxRdata, 32'hA5A5_1234);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd) begin
        regRead({16'd0, VECS[i].idx}, rdVal);
        chk($sformatf("R%0d vec %0d read", VECS[i].req, i), rdVal, VECS[i].data);
      end else begin
        regWrite({16'd0, VECS[i].idx}, VECS[i].data);
      end
      chk($sformatf("R%0d vec %0d badReg", VECS[i].req, i), {31'd0, badReg}, {31'd0, VECS[i].expBad});
    end
    chk("R10 cursor id out", cursorIdOut, 32'd5);
    chk("R10 cursor x out", cursorXOut, 32'd100);
    chk("R10 cursor y out", cursorYOut, 32'd200);
    chk("R10 cursor visible out", {31'd0, cursorVisible}, 32'd0);

    // R7 mode update: pending 800x600 not yet active
    chk("R7 width before update", widthOut, 32'd640);
    @(negedge clk); modeUpdate = 1'b1;
    @(negedge clk); modeUpdate = 1'b0;
    chk("R7 width after update", widthOut, 32'd800);
    chk("R7 height after update", heightOut, 32'd600);
    chk("R7 sizeChanged pulse", {31'd0, sizeChanged}, 32'd1);
    @(negedge clk);
    chk("R7 sizeChanged drops", {31'd0, sizeChanged}, 32'd0);
    @(negedge clk); modeUpdate = 1'b1;
    @(negedge clk); modeUpdate = 1'b0;
    chk("R7 no pulse when equal", {31'd0, sizeChanged}, 32'd0);

    // R5 depth writes
    regWrite(32'd7, 32'd24);
    chk("R5 matching depth no error", {31'd0, depthErr}, 32'd0);
    regWrite(32'd7, 32'd32);
    chk("R5 mismatched depth error", {31'd0, depthErr}, 32'd1);
    regRead(32'd7, rdVal);
    chk("R5 depth unchanged", rdVal, 32'd24);

    // R9 rejections
    setRing(32'd16, 32'h10000, 32'd18, 32'd16);
    regWrite(32'd20, 32'd1);
    chk("R9 misaligned ringErr", {31'd0, ringErr}, 32'd1);
    chk("R9 misaligned config", {31'd0, configOut}, 32'd0);
    setRing(32'd16, 32'h10004, 32'd16, 32'd16);
    regWrite(32'd20, 32'd1);
    chk("R9 max too big ringErr", {31'd0, ringErr}, 32'd1);
    chk("R9 max too big config", {31'd0, configOut}, 32'd0);
    setRing(32'd16, 32'd10252, 32'd16, 32'd16);
    regWrite(32'd20, 32'd1);
    chk("R9 span short ringErr", {31'd0, ringErr}, 32'd1);
    chk("R9 span short base", ringBase, 32'd0);

    // R8 acceptance at the exact span boundary
    setRing(32'd16, 32'd10256, 32'd16, 32'd16);
    regWrite(32'd20, 32'd1);
    chk("R8 accepted ringErr", {31'd0, ringErr}, 32'd0);
    chk("R8 accepted config", {31'd0, configOut}, 32'd1);
    chk("R8 ring base", ringBase, 32'd16);
    chk("R8 ring limit", ringLimit, 32'd10256);
    regRead(32'd20, rdVal);
    chk("R8 config readback", rdVal, 32'd1);
    regWrite(32'd20, 32'd0);
    chk("R8 zero clears config", {31'd0, configOut}, 32'd0);

    // R3 enable zero clears config
    setRing(32'd16, 32'h10000, 32'd32, 32'd64);
    regWrite(32'd20, 32'd1);
    chk("R8 config again", {31'd0, configOut}, 32'd1);
    setRing(32'd16, 32'h10000, 32'd18, 32'd64);
    regWrite(32'd20, 32'd1);
    chk("R9 reject keeps config", {31'd0, configOut}, 32'd1);
    chk("R9 reject keeps limit", ringLimit, 32'h10000);
    regWrite(32'd1, 32'd0);
    chk("R3 enable cleared", {31'd0, enableOut}, 32'd0);
    chk("R3 config cleared", {31'd0, configOut}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule